// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block sits between an 8-bit processor bus (16-bit address, 8-bit data, separate read and write strobes) and the external storage of a plug-in cartridge: a large ROM, a four-bank battery-backed RAM and a separate timekeeper block. Processor writes into the lower half of the address space never reach the ROM. The block decodes them into four control registers instead: a RAM enable, a ROM bank number, a shared RAM-bank / timekeeper-register select, and a latch control.

Processor reads in the lower half are translated into physical ROM addresses. The bottom 16 KiB window always shows bank 0. The upper 16 KiB window shows the selected bank. The 8 KiB window at 0xA000 goes either to the selected RAM bank or to the selected timekeeper register, depending on the last select written. The block drives a register index, a latch strobe and a write strobe toward the timekeeper, and returns the matching read data to the processor. The storage arrays and the time counting are outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write with cpu_addr in 0x0000–0x1FFF enables the RAM window when cpu_wdata[3:0] is 0xA, whatever the upper nibble holds. Any other low nibble disables it.
- R2: A write in 0x2000–0x3FFF stores cpu_wdata[6:0] as the ROM bank number. When those 7 bits are zero, bank 1 is stored instead, so 0x00 and 0x80 both select bank 1.
- R3: When cpu_addr is in 0x0000–0x3FFF, rom_addr equals cpu_addr[13:0] with zero upper bits. When cpu_addr is in 0x4000–0x7FFF, rom_addr equals bank × 0x4000 + cpu_addr[13:0], which is 21 bits wide.
- R4: A write in 0x4000–0x5FFF of a value 0x00–0x03 selects that RAM bank and memory mode. In memory mode ram_addr equals bank × 0x2000 + cpu_addr[12:0].
- R5: A write in 0x4000–0x5FFF of a value 0x08–0x0C selects timekeeper mode and sets tm_sel to value − 8. Any other value leaves the mode, the RAM bank and tm_sel unchanged.
- R6: While the RAM window is disabled, reads of 0xA000–0xBFFF return 0xFF, and writes there raise neither ram_we nor tm_we.
- R7: A write in 0x6000–0x7FFF raises tm_latch in the same cycle only if the previously stored value was 0x00 and the new value is 0x01. Every such write stores its value.
- R8: After reset the ROM bank is 1, the RAM bank is 0, the RAM window is disabled, memory mode is selected, tm_sel is 0, and the stored latch value is 0x01. A first write of 0x01 therefore does not latch.
- R9: cpu_rdata returns rom_rdata for 0x0000–0x7FFF. In the enabled RAM window it returns ram_rdata in memory mode and tm_rdata in timekeeper mode. For 0x8000–0x9FFF and 0xC000–0xFFFF it returns 0xFF.
- R10: A write to the enabled RAM window raises ram_we in memory mode and tm_we in timekeeper mode, never both. Register writes take effect at the clock edge that samples cpu_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data, also routed to RAM and timekeeper |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_oe | output | 1 | ROM output enable (read in the ROM windows) |
| rom_rdata | input | 8 | ROM data |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_oe | output | 1 | RAM output enable (enabled, memory mode) |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM data |
| tm_sel | output | 3 | Selected timekeeper register |
| tm_latch | output | 1 | Timekeeper latch strobe |
| tm_we | output | 1 | Timekeeper register write strobe |
| tm_rdata | input | 8 | Latched timekeeper register data |

## Verification
The select register is driven with values from all of its classes: memory banks 0–3, timekeeper indices 8–12, and the gaps 4–7 and above 12. This separates a correct class decode from an off-by-one range or a missing "leave unchanged" path. The ROM bank register is driven with 0x00, 0x80 and random values, so a mapper that tests for zero before masking, or that does not substitute bank 1 at all, shows up in rom_addr for reads of the upper window. Latch writes use sequences such as 1 after reset, 0-then-1, 1-then-1 and 2-then-1, which tell an edge detector on the stored value apart from a plain "value is 1" decode. Random reads over the whole address space, taken after random control writes, compare cpu_rdata with distinct data on each source. This exposes a wrong window boundary or mode steering.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
   // What the RAM window is steered to.
   typedef enum logic {
      WIN_MEM = 1'b0,
      WIN_TIME = 1'b1
   } win_mode_e;

   // Control register regions within 0x0000-0x7FFF, decoded from addr[14:13].
   typedef enum logic [1:0] {
      REG_ENABLE = 2'd0,
      REG_ROMBANK = 2'd1,
      REG_SELECT = 2'd2,
      REG_LATCH = 2'd3
   } ctl_reg_e;

   localparam int ROM_WIN_W = 14;   // 16 KiB ROM window offset
   localparam int RAM_WIN_W = 13;   // 8 KiB RAM window offset
endpackage

// File: rtl/cbm_regs.sv
`timescale 1ns/1ps
module cbm_regs
   import cbm_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter int TM_IDX_W = 3,
   parameter int TM_REGS = 5,
   parameter int TM_SEL_BASE = 8,
   parameter logic [3:0] ENABLE_KEY = 4'hA,
   parameter bit MASK_BEFORE_ZERO = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            addr_hi,
   input  logic [7:0]            wdata,
   output logic                  ram_en,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output win_mode_e             mode,
   output logic [TM_IDX_W-1:0]   tm_idx,
   output logic                  latch_pulse
);
   localparam int RAM_BANKS = 1 << RAM_BANK_W;
   localparam logic [7:0] MEM_LIM = 8'(RAM_BANKS);
   localparam logic [7:0] TM_LO = 8'(TM_SEL_BASE);
   localparam logic [7:0] TM_HI = 8'(TM_SEL_BASE + TM_REGS);
   localparam logic [ROM_BANK_W-1:0] BANK_ONE = ROM_BANK_W'(1);

   if (ROM_BANK_W < 1 || ROM_BANK_W > 8) begin : g_bad_rom_w
      initial $fatal(1, "cbm_regs: ROM_BANK_W must be 1..8");
   end
   if (RAM_BANK_W < 1 || RAM_BANK_W > 3) begin : g_bad_ram_w
      initial $fatal(1, "cbm_regs: RAM_BANK_W must be 1..3");
   end
   if (TM_REGS > (1 << TM_IDX_W) || TM_SEL_BASE < RAM_BANKS
       || TM_SEL_BASE + TM_REGS > 256) begin : g_bad_tm
      initial $fatal(1, "cbm_regs: timekeeper select range does not fit");
   end

   logic       wr_ctl;
   ctl_reg_e   region;
   logic       sel_mem, sel_tm;
   logic [7:0] latch_last;
   logic [ROM_BANK_W-1:0] bank_masked, bank_next;

   assign wr_ctl = wr_en && !addr_hi[2];
   assign region = ctl_reg_e'(addr_hi[1:0]);
   assign sel_mem = wdata < MEM_LIM;
   assign sel_tm = (wdata >= TM_LO) && (wdata < TM_HI);
   assign bank_masked = wdata[ROM_BANK_W-1:0];

   // Variant: test for a zero bank after masking, or on the raw byte.
   if (MASK_BEFORE_ZERO) begin : g_zero_masked
      assign bank_next = (bank_masked == '0) ? BANK_ONE : bank_masked;
   end else begin : g_zero_raw
      assign bank_next = (wdata == 8'h00) ? BANK_ONE : bank_masked;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_en <= 1'b0;
         rom_bank <= BANK_ONE;
         ram_bank <= '0;
         mode <= WIN_MEM;
         tm_idx <= '0;
         latch_last <= 8'h01;
      end else if (wr_ctl) begin
         unique case (region)
            REG_ENABLE: ram_en <= (wdata[3:0] == ENABLE_KEY);
            REG_ROMBANK: rom_bank <= bank_next;
            REG_SELECT: begin
               if (sel_mem) begin
                  mode <= WIN_MEM;
                  ram_bank <= wdata[RAM_BANK_W-1:0];
               end else if (sel_tm) begin
                  mode <= WIN_TIME;
                  tm_idx <= TM_IDX_W'(wdata - TM_LO);
               end
            end
            REG_LATCH: latch_last <= wdata;
            default: ;
         endcase
      end
   end

   assign latch_pulse = wr_ctl && (region == REG_LATCH)
                        && (latch_last == 8'h00) && (wdata == 8'h01);

   // R1: the enable follows the key nibble of the last enable write
   p_enable_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && region == REG_ENABLE) |=> (ram_en == ($past(wdata[3:0]) == ENABLE_KEY)));

   if (MASK_BEFORE_ZERO) begin : g_chk_nonzero
      // R2: bank 0 can never be selected for the upper window
      p_bank_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
         rom_bank != '0);
   end

   // R5: values outside both select classes leave the steering untouched
   p_select_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && region == REG_SELECT && !sel_mem && !sel_tm)
      |=> ($stable(mode) && $stable(tm_idx) && $stable(ram_bank)));

   // R7: a latch strobe stores 1, so the next cycle cannot strobe again
   p_latch_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      latch_pulse |=> !latch_pulse);
endmodule

// File: rtl/cbm_addr_map.sv
`timescale 1ns/1ps
module cbm_addr_map
   import cbm_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   localparam int ROM_ADDR_W = ROM_BANK_W + ROM_WIN_W,
   localparam int RAM_ADDR_W = RAM_BANK_W + RAM_WIN_W
) (
   input  logic [15:0]           addr,
   input  logic [ROM_BANK_W-1:0] rom_bank,
   input  logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  in_rom,
   output logic                  in_ram,
   output logic [ROM_ADDR_W-1:0] rom_addr,
   output logic [RAM_ADDR_W-1:0] ram_addr
);
   logic [ROM_BANK_W-1:0] eff_bank;

   assign in_rom = !addr[15];
   assign in_ram = (addr[15:13] == 3'b101);
   // The lower window is pinned to bank 0, the upper one follows the register.
   assign eff_bank = addr[14] ? rom_bank : '0;
   assign rom_addr = {eff_bank, addr[ROM_WIN_W-1:0]};
   assign ram_addr = {ram_bank, addr[RAM_WIN_W-1:0]};
endmodule

// File: rtl/cbm_rdata_mux.sv
`timescale 1ns/1ps
module cbm_rdata_mux
   import cbm_pkg::*;
#(
   parameter logic [7:0] OPEN_BUS = 8'hFF
) (
   input  logic       in_rom,
   input  logic       in_ram,
   input  logic       ram_en,
   input  win_mode_e  mode,
   input  logic [7:0] rom_rdata,
   input  logic [7:0] ram_rdata,
   input  logic [7:0] tm_rdata,
   output logic [7:0] rdata
);
   always_comb begin
      rdata = OPEN_BUS;
      if (in_rom) begin
         rdata = rom_rdata;
      end else if (in_ram && ram_en) begin
         rdata = (mode == WIN_TIME) ? tm_rdata : ram_rdata;
      end
   end
endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter int TM_IDX_W = 3,
   parameter int TM_REGS = 5,
   parameter int TM_SEL_BASE = 8,
   parameter logic [3:0] ENABLE_KEY = 4'hA,
   parameter bit MASK_BEFORE_ZERO = 1'b1,
   localparam int ROM_ADDR_W = ROM_BANK_W + ROM_WIN_W,
   localparam int RAM_ADDR_W = RAM_BANK_W + RAM_WIN_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cpu_addr,
   input  logic [7:0]            cpu_wdata,
   input  logic                  cpu_rd,
   input  logic                  cpu_wr,
   output logic [7:0]            cpu_rdata,
   output logic [ROM_ADDR_W-1:0] rom_addr,
   output logic                  rom_oe,
   input  logic [7:0]            rom_rdata,
   output logic [RAM_ADDR_W-1:0] ram_addr,
   output logic                  ram_oe,
   output logic                  ram_we,
   input  logic [7:0]            ram_rdata,
   output logic [TM_IDX_W-1:0]   tm_sel,
   output logic                  tm_latch,
   output logic                  tm_we,
   input  logic [7:0]            tm_rdata
);
   logic                  ram_en;
   logic [ROM_BANK_W-1:0] rom_bank;
   logic [RAM_BANK_W-1:0] ram_bank;
   win_mode_e             mode;
   logic                  in_rom, in_ram, ram_live;

   cbm_regs #(
      .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .TM_IDX_W(TM_IDX_W),
      .TM_REGS(TM_REGS), .TM_SEL_BASE(TM_SEL_BASE), .ENABLE_KEY(ENABLE_KEY),
      .MASK_BEFORE_ZERO(MASK_BEFORE_ZERO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr_hi(cpu_addr[15:13]),
      .wdata(cpu_wdata), .ram_en(ram_en), .rom_bank(rom_bank),
      .ram_bank(ram_bank), .mode(mode), .tm_idx(tm_sel), .latch_pulse(tm_latch)
   );

   cbm_addr_map #(
      .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)
   ) u_map (
      .addr(cpu_addr), .rom_bank(rom_bank), .ram_bank(ram_bank),
      .in_rom(in_rom), .in_ram(in_ram), .rom_addr(rom_addr), .ram_addr(ram_addr)
   );

   cbm_rdata_mux u_mux (
      .in_rom(in_rom), .in_ram(in_ram), .ram_en(ram_en), .mode(mode),
      .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .tm_rdata(tm_rdata),
      .rdata(cpu_rdata)
   );

   assign ram_live = in_ram && ram_en;
   assign rom_oe = cpu_rd && in_rom;
   assign ram_oe = cpu_rd && ram_live && (mode == WIN_MEM);
   assign ram_we = cpu_wr && ram_live && (mode == WIN_MEM);
   assign tm_we = cpu_wr && ram_live && (mode == WIN_TIME);

   // R6: a disabled window raises no write strobe of either kind
   p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_en |-> (!ram_we && !tm_we));

   // R6: a disabled window reads as open bus
   p_off_openbus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b101 && !ram_en) |-> (cpu_rdata == 8'hFF));

   // R10: storage write, timekeeper write and latch are mutually exclusive
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_we, tm_we, tm_latch}));

   // R3: the lower ROM window always resolves to bank 0
   p_fixed_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_ADDR_W-1:ROM_WIN_W] == '0));
endmodule

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0]  cpu_rdata;
   logic [20:0] rom_addr;
   logic        rom_oe, ram_oe, ram_we, tm_latch, tm_we;
   logic [7:0]  rom_rdata = 8'h3C, ram_rdata = 8'hC3, tm_rdata = 8'h66;
   logic [14:0] ram_addr;
   logic [2:0]  tm_sel;

   int n_checks = 0, n_errors = 0;
   bit finished = 1'b0;

   // bench model of the control state
   bit       m_en;
   int       m_rom, m_ram, m_idx;
   bit       m_tm;
   int       m_last;

   always #10 clk = ~clk;   // 50 MHz

   cart_bank_mapper u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .rom_addr(rom_addr), .rom_oe(rom_oe), .rom_rdata(rom_rdata),
      .ram_addr(ram_addr), .ram_oe(ram_oe), .ram_we(ram_we),
      .ram_rdata(ram_rdata), .tm_sel(tm_sel), .tm_latch(tm_latch),
      .tm_we(tm_we), .tm_rdata(tm_rdata)
   );

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int f_rom_addr(int a, int bank);
      if (a < 'h4000) return a;
      return bank * 'h4000 + (a - 'h4000);
   endfunction

   function automatic int f_rdata(int a);
      if (a < 'h8000) return rom_rdata;
      if (a >= 'hA000 && a < 'hC000) begin
         if (!m_en) return 'hFF;
         return m_tm ? tm_rdata : ram_rdata;
      end
      return 'hFF;
   endfunction

   task automatic model_reset();
      m_en = 0; m_rom = 1; m_ram = 0; m_tm = 0; m_idx = 0; m_last = 1;
   endtask

   task automatic do_write(int a, int d);
      int exp_latch;
      @(negedge clk);
      cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
      #1;
      exp_latch = (a >= 'h6000 && a < 'h8000 && m_last == 0 && d == 1) ? 1 : 0;
      check("R7 tm_latch", int'(tm_latch), exp_latch);
      if (a >= 'hA000 && a < 'hC000) begin
         check("R6/R10 ram_we", int'(ram_we), (m_en && !m_tm) ? 1 : 0);
         check("R6/R10 tm_we", int'(tm_we), (m_en && m_tm) ? 1 : 0);
      end
      @(posedge clk);
      #1 cpu_wr = 1'b0;
      if (a < 'h2000) m_en = ((d & 'hF) == 'hA);
      else if (a < 'h4000) m_rom = ((d & 'h7F) == 0) ? 1 : (d & 'h7F);
      else if (a < 'h6000) begin
         if (d <= 3) begin m_tm = 0; m_ram = d; end
         else if (d >= 8 && d <= 12) begin m_tm = 1; m_idx = d - 8; end
      end else if (a < 'h8000) m_last = d;
   endtask

   task automatic do_read(int a, string req);
      @(negedge clk);
      cpu_addr = 16'(a); cpu_rd = 1'b1;
      rom_rdata = 8'($urandom); ram_rdata = 8'($urandom); tm_rdata = 8'($urandom);
      #1;
      if (a < 'h8000) check({req, " rom_addr"}, int'(rom_addr), f_rom_addr(a, m_rom));
      if (a >= 'hA000 && a < 'hC000 && !m_tm)
         check({req, " ram_addr"}, int'(ram_addr), m_ram * 'h2000 + (a - 'hA000));
      check({req, " cpu_rdata"}, int'(cpu_rdata), f_rdata(a));
      check({req, " tm_sel"}, int'(tm_sel), m_idx);
      cpu_rd = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20250611));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset state seen at the ports
      do_read('h4123, "R8 bank1");
      do_read('hA010, "R8 disabled");
      do_write('h6000, 1);           // R8: stored 1, no latch
      do_write('h6000, 0);
      do_write('h7FFF, 1);           // R7: 0 then 1 latches
      do_write('h6000, 1);           // R7: 1 then 1 does not
      do_write('h6000, 2);
      do_write('h6000, 1);           // R7: 2 then 1 does not

      // R2: zero substitution after masking
      do_write('h2000, 'h00); do_read('h4000, "R2 zero");
      do_write('h3FFF, 'h80); do_read('h7FFF, "R2 0x80");
      do_write('h2100, 'h85); do_read('h5555, "R2 0x85");
      do_write('h2000, 'h7F); do_read('h4001, "R2 max");
      do_read('h0123, "R3 fixed");

      // R1: key nibble, upper nibble ignored
      do_write('h0000, 'h1A); do_read('hA000, "R1 enable");
      do_write('h1FFF, 'h0B); do_read('hA000, "R1 disable");
      do_write('h0000, 'h0A);

      // R4/R5: select classes and gaps
      do_write('h4000, 'h02); do_read('hBFFF, "R4 bank2");
      do_write('h5000, 'h0A); do_read('hA001, "R5 idx2");
      do_write('h4000, 'h05); do_read('hA001, "R5 gap5");
      do_write('h4000, 'h0D); do_read('hA002, "R5 gap13");
      do_write('h4000, 'hFF); do_read('hA002, "R5 gapFF");
      do_write('h4000, 'h0C); do_read('hA003, "R5 idx4");
      do_write('hA003, 'h55);        // R10: tm_we
      do_write('h4000, 'h03); do_write('hB000, 'h12); // R10: ram_we
      do_read('h8000, "R9 gap"); do_read('hC000, "R9 high");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int kind = $urandom_range(0, 4);
         int a, d;
         case (kind)
            0: begin a = $urandom_range(0, 'h1FFF); d = ($urandom_range(0, 1) != 0) ? 'h0A : $urandom_range(0, 255); end
            1: begin a = $urandom_range('h2000, 'h3FFF); d = $urandom_range(0, 255); end
            2: begin a = $urandom_range('h4000, 'h5FFF); d = $urandom_range(0, 15); end
            3: begin a = $urandom_range('h6000, 'h7FFF); d = $urandom_range(0, 2); end
            default: begin a = $urandom_range('hA000, 'hBFFF); d = $urandom_range(0, 255); end
         endcase
         do_write(a, d);
         do_read($urandom_range(0, 'hFFFF), "R9 random");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule